// File: doc/BRIEF.md
# Single-Endpoint-Pair DMA Channel

This block is one DMA channel that moves a single byte or a single 16-bit word each time its selected peripheral raises a request, and stops after a programmed number of such moves. One endpoint is a memory address that steps after every move. The other is an I/O address that never changes. No control bit sets the direction. It follows from the chosen request source: the serial-receive-full source copies from the I/O address into memory, and every other source copies from memory out to the I/O address.

Software programs the channel through a small write-only register port: memory address, I/O address, transfer count and a control word. It then sets the enable bit. Each accepted request produces one read cycle and then one write cycle on a single-beat bus master port, and each cycle waits for `bus_ready`. When the count runs out, the channel clears its own enable bit and latches a done condition. If interrupts are enabled, this drives `irq` high until software next writes the control word.

Top module: `dma_pair_channel`

## Requirements
- R1: Writes with `cfg_we` high load the register chosen by `cfg_sel`: 0 = memory address, 1 = I/O address, 2 = transfer count (low CW bits), 3 = control. The control bits are: bit0 enable, bit1 repeat, bit2 interrupt enable, bit3 decrement, bit4 word size, and bits [5+SW-1:5] request source index.
- R2: Each accepted request produces exactly one read cycle (`bus_write`=0) followed by exactly one write cycle (`bus_write`=1). `bus_valid`, `bus_addr` and `bus_write` stay stable until `bus_ready` is seen high at a clock edge.
- R3: When the source index equals RX_SRC (4 by default), the read is at the I/O address and the write is at the memory address. For any other source, the read is at the memory address and the write is at the I/O address.
- R4: After each write cycle, the memory address rises (decrement bit 0) or falls (decrement bit 1) by 1 in byte mode or by 2 in word mode, wrapping modulo 2^AW. The I/O address never changes.
- R5: In word mode `bus_word` is 1 and bit 0 of `bus_addr` is forced to 0. In byte mode `bus_word` is 0 and the address is passed through unchanged.
- R6: After the programmed count of transfers, the enable bit clears and further requests start no bus cycle. A count of 0 performs 2^CW transfers.
- R7: `irq` is high exactly when the done condition is latched and the interrupt-enable bit is 1. It stays high until the next control write, which clears the done condition.
- R8: A transfer starts only from idle, and only when enable is 1, repeat is 0 and the request input named by the source index is high. Requests on other inputs, or with the repeat bit set, start nothing.
- R9: The write cycle carries the data returned by the preceding read cycle.
- R10: After reset `bus_valid` and `irq` are 0 and all registers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| req | input | NSRC | Request lines, one per source |
| bus_valid | output | 1 | Bus cycle active |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled when ready |
| bus_ready | input | 1 | Ends the current cycle |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bench builds the channel with AW=16, CW=8, NSRC=8 and RX_SRC=4. The narrow address makes wrap-around from 0xFFFF upward and from 0 downward easy to reach. The 8-bit count lets a zero count run its full 256 transfers in a short run. Eight sources with source 4 as the receive source let random configurations exercise both directions and the ignored-source case.

// File: rtl/dma_pair_channel.sv
module dma_pair_channel #(
  parameter int AW     = 24,
  parameter int CW     = 16,
  parameter int DW     = 16,
  parameter int NSRC   = 8,
  parameter int RX_SRC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [NSRC-1:0] req,
  output logic          bus_valid,
  output logic          bus_write,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          irq
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [SW-1:0] RX_ID = SW'(RX_SRC);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t            st;
  logic [AW-1:0]  mar, ioar, a_raw, step, mar_nx;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  hold;
  logic [SW-1:0]  src;
  logic           en, rep, ie, dec, wsz, done;
  logic           rx, go, last;

  assign rx     = (src == RX_ID);
  assign go     = en & ~rep & req[src];
  assign last   = (cnt == CW'(1));
  assign step   = wsz ? AW'(2) : AW'(1);
  assign mar_nx = dec ? mar - step : mar + step;
  assign a_raw  = (st == S_WR) ? (rx ? mar : ioar) : (rx ? ioar : mar);

  assign bus_valid = (st != S_IDLE);
  assign bus_write = (st == S_WR);
  assign bus_word  = wsz;
  assign bus_addr  = wsz ? {a_raw[AW-1:1], 1'b0} : a_raw;
  assign bus_wdata = hold;
  assign irq       = done & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mar <= '0; ioar <= '0; cnt <= '0; hold <= '0;
      src <= '0; en <= 1'b0; rep <= 1'b0; ie <= 1'b0; dec <= 1'b0;
      wsz <= 1'b0; done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) st <= S_RD;
        S_RD: if (bus_ready) begin
          hold <= bus_rdata;
          st   <= S_WR;
        end
        S_WR: if (bus_ready) begin
          st  <= S_IDLE;
          mar <= mar_nx;
          cnt <= cnt - CW'(1);
          if (last) begin
            en   <= 1'b0;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: mar  <= cfg_wdata;
          2'd1: ioar <= cfg_wdata;
          2'd2: cnt  <= cfg_wdata[CW-1:0];
          default: begin
            en   <= cfg_wdata[0];
            rep  <= cfg_wdata[1];
            ie   <= cfg_wdata[2];
            dec  <= cfg_wdata[3];
            wsz  <= cfg_wdata[4];
            src  <= cfg_wdata[5+SW-1:5];
            done <= 1'b0;
          end
        endcase
      end
    end
  end

  a_r2_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_ready |=> bus_valid && bus_write);

  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_word |-> !bus_addr[0]);

  a_r6_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid && !en);

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(cfg_we && cfg_sel == 2'd3) |=> irq);

  a_r8_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid && !go |=> !bus_valid);

  a_r4_io_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_sel == 2'd1) |=> $stable(ioar));
endmodule

// File: tb/dma_pair_channel_tb.sv
module dma_pair_channel_tb;
  localparam int AW = 16, CW = 8, DW = 16, NSRC = 8, RX = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic [NSRC-1:0] req = 0;
  logic bus_valid, bus_write, bus_word, irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_ready = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] f_data(input logic [AW-1:0] a);
    return DW'(a * 3 + 16'h1234);
  endfunction

  assign bus_rdata = f_data(bus_addr);

  dma_pair_channel #(.AW(AW), .CW(CW), .DW(DW), .NSRC(NSRC), .RX_SRC(RX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req(req), .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [AW-1:0] ctl(input bit en, rep, ie, dec, wsz, input int src);
    return AW'({src[2:0], wsz, dec, ie, rep, en});
  endfunction

  function automatic logic [AW-1:0] mar_at(input logic [AW-1:0] b, input int k, input bit dec, wsz);
    int s = wsz ? 2 : 1;
    return dec ? AW'(b - k * s) : AW'(b + k * s);
  endfunction

  task automatic one_xfer(input int src, input logic [AW-1:0] rd_e, wr_e, input bit wsz);
    logic [AW-1:0] ra;
    int beat = 0, guard = 0;
    @(negedge clk); req[src] = 1;
    @(negedge clk); req[src] = 0;
    while (beat < 2 && guard < 60) begin
      bus_ready = ($urandom % 4) != 0;
      if (bus_valid && bus_ready) begin
        if (beat == 0) begin
          ra = bus_addr;
          chk(!bus_write, "R2", "first cycle is read", bus_write, 0);
          chk(bus_addr == rd_e, "R3", "read address", bus_addr, rd_e);
          chk(bus_word == wsz, "R5", "size", bus_word, wsz);
        end else begin
          chk(bus_write, "R2", "second cycle is write", bus_write, 1);
          chk(bus_addr == wr_e, "R4", "write address", bus_addr, wr_e);
          chk(bus_wdata == f_data(ra), "R9", "write data", bus_wdata, f_data(ra));
        end
        beat++;
      end
      guard++;
      @(negedge clk);
    end
    bus_ready = 0;
    chk(beat == 2, "R2", "beats per request", beat, 2);
  endtask

  task automatic quiet(input int bitn, input string rq);
    bit seen = 0;
    @(negedge clk); req[bitn] = 1;
    @(negedge clk); req[bitn] = 0;
    for (int i = 0; i < 8; i++) begin
      if (bus_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, rq, "no bus cycle", seen, 0);
  endtask

  task automatic run_case(input logic [AW-1:0] m0, io0, input int n, input bit dec, wsz, ie, input int src);
    int total = (n == 0) ? 256 : n;
    logic [AW-1:0] m, ra, wa, io;
    wr(2'd0, m0); wr(2'd1, io0); wr(2'd2, AW'(n));
    wr(2'd3, ctl(1, 0, ie, dec, wsz, src));
    for (int k = 0; k < total; k++) begin
      m  = mar_at(m0, k, dec, wsz);
      io = io0;
      if (wsz) begin m[0] = 0; io[0] = 0; end
      ra = (src == RX) ? io : m;
      wa = (src == RX) ? m : io;
      one_xfer(src, ra, wa, wsz);
    end
    chk(irq == ie, "R7", "irq at completion", irq, ie);
    quiet(src, "R6");
    chk(irq == ie, "R7", "irq held", irq, ie);
    if (ie) begin
      wr(2'd3, 0);
      chk(irq == 0, "R7", "irq cleared by control write", irq, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_valid == 0 && irq == 0, "R10", "reset outputs", {bus_valid, irq}, 0);
    rst_n = 1;
    quiet(0, "R10");
    void'($urandom(32'h5eed));
    run_case(16'h1000, 16'h0040, 3, 0, 0, 1, 2);
    run_case(16'h2001, 16'h0081, 3, 1, 1, 1, RX);
    run_case(16'hFFFE, 16'h0010, 4, 0, 0, 0, 1);
    run_case(16'h0001, 16'h0020, 3, 1, 1, 1, 0);
    run_case(16'h0100, 16'h0030, 0, 0, 0, 1, RX);
    wr(2'd0, 16'h3000); wr(2'd1, 16'h50); wr(2'd2, 5);
    wr(2'd3, ctl(1, 0, 1, 0, 0, 2));
    quiet(5, "R8");
    wr(2'd3, ctl(1, 1, 1, 0, 0, 2));
    quiet(2, "R8");
    wr(2'd3, ctl(0, 0, 1, 0, 0, 2));
    quiet(2, "R1");
    for (int r = 0; r < 6; r++)
      run_case(AW'($urandom), AW'($urandom), 1 + $urandom % 5, $urandom % 2,
               $urandom % 2, $urandom % 2, $urandom % 8);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule